// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus. After reset it keeps the clock enable low and the chip deselected for the power-up interval. It then raises the clock enable and issues the fixed bring-up series of commands. The series is: precharge-all, extended mode set to enable the DLL, mode set with DLL reset, a NOP window for DLL lock, a second precharge-all, two auto refreshes, and a final mode set without DLL reset. When the last command's settle time has passed, it raises `init_done` so that a normal scheduler can take the bus.

Each wait in nanoseconds is turned into clock cycles by rounding the delay up to a whole number of `CLK_PERIOD_PS` periods. Every gap is counted by one shared down-counter. The burst length, burst type, CAS latency and drive strength written into the mode registers are read from input ports when the matching command is issued.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, `cke` stays low for exactly P = ceil(POWERUP_NS*1000 / CLK_PERIOD_PS) clock cycles. It then rises and stays high until the next reset.
- R2: `cs_n` is high (deselect, with `ras_n`, `cas_n` and `we_n` all high) in every cycle that carries no command. This includes every cycle with `cke` low and the cycle in which `cke` rises. The first command comes one cycle after `cke` rises.
- R3: Commands are issued with `cs_n` low and {`ras_n`,`cas_n`,`we_n`} set to 010 for precharge, 001 for auto refresh and 000 for mode set. The order is fixed: precharge-all with address bit 10 = 1 and all other address bits 0, extended mode set on `ba`=01, mode set on `ba`=00 with DLL reset, precharge-all, refresh, refresh, and mode set on `ba`=00 without DLL reset.
- R4: Gaps are counted from one command to the next. After a precharge the gap is ceil(TRP_NS*1000/CLK_PERIOD_PS). After an extended mode set it is TMRD_CK. After the DLL-reset mode set it is max(DLL_LOCK_CK, TMRD_CK). After each refresh it is ceil(TRFC_NS*1000/CLK_PERIOD_PS).
- R5: The mode set address carries `cfg_burst_len` on bits 2:0, `cfg_interleave` on bit 3 and `cfg_cas_lat` on bits 6:4. Bit 8 is 1 for the DLL-reset mode set and 0 for the final one. All other bits are 0.
- R6: The extended mode set address has bit 0 = 0 (DLL enabled) and bit 1 = `cfg_drive_reduced`. All other bits are 0.
- R7: `init_done` rises exactly TMRD_CK cycles after the final mode set. It stays high until reset, and the bus stays deselected while it is high.
- R8: While `rst` is high, at any point in the sequence, the outputs go to `cke`=0, deselect, `ba`=0, `addr`=0 and `init_done`=0. After release the whole sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst length code for the mode register |
| cfg_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code for the mode register |
| cfg_drive_reduced | input | 1 | Drive strength bit for the extended mode register |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the bus may be handed to a scheduler |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through the sequence, for example during the long DLL-lock wait or between the two refreshes. In that case the shared counter and the step state must both drop back cleanly. The bench builds its own timeline of expected command cycles and uses those cycle numbers to raise reset at exact points. It then checks every cycle of the rerun. The bench also sets the precharge and refresh delays to values that are not whole multiples of the clock period, so that the rounding-up of the gaps is visible on the bus.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W        = 13,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int POWERUP_NS    = 200000,
  parameter int TRP_NS        = 20,
  parameter int TRFC_NS       = 80,
  parameter int TMRD_CK       = 2,
  parameter int DLL_LOCK_CK   = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_drive_reduced,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int PWR_RAW  = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int TRP_RAW  = (TRP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int TRFC_RAW = (TRFC_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int PWR_CK   = (PWR_RAW < 1) ? 1 : PWR_RAW;
  localparam int TRP_CK   = (TRP_RAW < 1) ? 1 : TRP_RAW;
  localparam int TRFC_CK  = (TRFC_RAW < 1) ? 1 : TRFC_RAW;
  localparam int TMRD_G   = (TMRD_CK < 1) ? 1 : TMRD_CK;
  localparam int DLL_G    = (DLL_LOCK_CK > TMRD_G) ? DLL_LOCK_CK : TMRD_G;
  localparam int MAX_A    = (PWR_CK > DLL_G) ? PWR_CK : DLL_G;
  localparam int MAX_B    = (TRFC_CK > TRP_CK) ? TRFC_CK : TRP_CK;
  localparam int LONGEST  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(LONGEST + 1);

  localparam logic [CNT_W-1:0] R_PWR  = CNT_W'(PWR_CK - 1);
  localparam logic [CNT_W-1:0] R_TRP  = CNT_W'(TRP_CK - 1);
  localparam logic [CNT_W-1:0] R_TRFC = CNT_W'(TRFC_CK - 1);
  localparam logic [CNT_W-1:0] R_MRD  = CNT_W'(TMRD_G - 1);
  localparam logic [CNT_W-1:0] R_DLL  = CNT_W'(DLL_G - 1);

  localparam logic [2:0] OP_PRE  = 3'b010;
  localparam logic [2:0] OP_REF  = 3'b001;
  localparam logic [2:0] OP_MODE = 3'b000;
  localparam logic [2:0] OP_IDLE = 3'b111;

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE_A, ST_EXT, ST_MRS_RST, ST_PRE_B,
    ST_REF_A, ST_REF_B, ST_MRS_RUN, ST_DONE
  } step_t;

  step_t             step, step_nx;
  logic [CNT_W-1:0]  cnt, reload;
  logic [2:0]        op_nx;
  logic [1:0]        ba_nx;
  logic              cs_nx;
  logic [ADDR_W-1:0] addr_nx, mode_word, ext_word, pre_word;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = cfg_burst_len;
    mode_word[3]   = cfg_interleave;
    mode_word[6:4] = cfg_cas_lat;
    ext_word       = '0;
    ext_word[1]    = cfg_drive_reduced;
    pre_word       = '0;
    pre_word[10]   = 1'b1;
  end

  always_comb begin
    step_nx = step;
    reload  = '0;
    cs_nx   = 1'b0;
    op_nx   = OP_IDLE;
    ba_nx   = 2'b00;
    addr_nx = '0;
    case (step)
      ST_PWR: begin
        cs_nx   = 1'b1;
        step_nx = ST_PRE_A;
      end
      ST_PRE_A: begin
        op_nx   = OP_PRE;
        addr_nx = pre_word;
        reload  = R_TRP;
        step_nx = ST_EXT;
      end
      ST_EXT: begin
        op_nx   = OP_MODE;
        ba_nx   = 2'b01;
        addr_nx = ext_word;
        reload  = R_MRD;
        step_nx = ST_MRS_RST;
      end
      ST_MRS_RST: begin
        op_nx      = OP_MODE;
        addr_nx    = mode_word;
        addr_nx[8] = 1'b1;
        reload     = R_DLL;
        step_nx    = ST_PRE_B;
      end
      ST_PRE_B: begin
        op_nx   = OP_PRE;
        addr_nx = pre_word;
        reload  = R_TRP;
        step_nx = ST_REF_A;
      end
      ST_REF_A: begin
        op_nx   = OP_REF;
        reload  = R_TRFC;
        step_nx = ST_REF_B;
      end
      ST_REF_B: begin
        op_nx   = OP_REF;
        reload  = R_TRFC;
        step_nx = ST_MRS_RUN;
      end
      ST_MRS_RUN: begin
        op_nx   = OP_MODE;
        addr_nx = mode_word;
        reload  = R_MRD;
        step_nx = ST_DONE;
      end
      default: begin
        cs_nx   = 1'b1;
        step_nx = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step                  <= ST_PWR;
      cnt                   <= R_PWR;
      cke                   <= 1'b0;
      cs_n                  <= 1'b1;
      {ras_n, cas_n, we_n}  <= OP_IDLE;
      ba                    <= 2'b00;
      addr                  <= '0;
      init_done             <= 1'b0;
    end else begin
      cs_n                  <= 1'b1;
      {ras_n, cas_n, we_n}  <= OP_IDLE;
      ba                    <= 2'b00;
      addr                  <= '0;
      if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else if (step == ST_DONE) begin
        init_done <= 1'b1;
      end else begin
        step                 <= step_nx;
        cnt                  <= reload;
        cke                  <= 1'b1;
        cs_n                 <= cs_nx;
        {ras_n, cas_n, we_n} <= op_nx;
        ba                   <= ba_nx;
        addr                 <= addr_nx;
      end
    end
  end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int PWR_CK  = 1,
  parameter int TRP_CK  = 1,
  parameter int TRFC_CK = 1,
  parameter int TMRD_G  = 1
) (
  input logic clk,
  input logic rst,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic init_done
);

  localparam int SAT = 1 << 20;

  logic [2:0] op;
  logic issue, is_pre, is_ref, is_mode;
  int low_cnt, since_pre, since_ref, since_mode;

  assign op      = {ras_n, cas_n, we_n};
  assign issue   = !cs_n && op != 3'b111;
  assign is_pre  = !cs_n && op == 3'b010;
  assign is_ref  = !cs_n && op == 3'b001;
  assign is_mode = !cs_n && op == 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= 0;
      since_pre  <= SAT;
      since_ref  <= SAT;
      since_mode <= SAT;
    end else begin
      if (!cke && low_cnt < SAT) low_cnt <= low_cnt + 1;
      since_pre  <= is_pre  ? 1 : (since_pre  < SAT ? since_pre  + 1 : SAT);
      since_ref  <= is_ref  ? 1 : (since_ref  < SAT ? since_ref  + 1 : SAT);
      since_mode <= is_mode ? 1 : (since_mode < SAT ? since_mode + 1 : SAT);
    end
  end

  p_cke_wait_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> low_cnt >= PWR_CK);
  p_cke_hold_r1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  p_desel_low_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n);
  p_rise_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> !issue);
  p_trp_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (is_ref || is_mode) |-> since_pre >= TRP_CK);
  p_trfc_gap_r4: assert property (@(posedge clk) disable iff (rst)
    issue |-> since_ref >= TRFC_CK);
  p_tmrd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    issue |-> since_mode >= TMRD_G);
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cs_n);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .PWR_CK(PWR_CK), .TRP_CK(TRP_CK), .TRFC_CK(TRFC_CK), .TMRD_G(TMRD_G)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .init_done(init_done)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;

  localparam int AW      = 13;
  localparam int CLK_PS  = 4000;
  localparam int PWR_NS  = 1000;
  localparam int TRP_NS  = 18;
  localparam int TRFC_NS = 75;
  localparam int TMRD    = 2;
  localparam int DLL     = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_bl = 3'b010;
  logic       cfg_il = 1'b0;
  logic [2:0] cfg_cl = 3'b011;
  logic       cfg_drv = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int tests = 0;
  int fails = 0;
  int n = 0;
  int t0, t1, t2, t3, t4, t5, t6, t7, t8;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(AW), .CLK_PERIOD_PS(CLK_PS), .POWERUP_NS(PWR_NS),
    .TRP_NS(TRP_NS), .TRFC_NS(TRFC_NS), .TMRD_CK(TMRD), .DLL_LOCK_CK(DLL)
  ) u_ddr_init_seq (
    .clk(clk), .rst(rst),
    .cfg_burst_len(cfg_bl), .cfg_interleave(cfg_il),
    .cfg_cas_lat(cfg_cl), .cfg_drive_reduced(cfg_drv),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  function automatic int to_cycles(int ns);
    int k = 0;
    while (k * CLK_PS < ns * 1000) k++;
    return k;
  endfunction

  task automatic check_cycle();
    int e_cke, e_cs, e_op, e_ba, e_addr, e_done, mr;
    int g_cke, g_cs, g_op, g_ba, g_addr, g_done;
    string tag;
    mr = (int'(cfg_cl) << 4) | (int'(cfg_il) << 3) | int'(cfg_bl);
    e_cke = (n >= t0) ? 1 : 0;
    e_cs = 1; e_op = 7; e_ba = 0; e_addr = 0;
    e_done = (n >= t8) ? 1 : 0;
    tag = "R4";
    if (n == 0) tag = "R8";
    else if (n < t0) tag = "R1";
    else if (n == t0) tag = "R2";
    else if (n >= t8) tag = "R7";
    if (n == t1 || n == t4) begin e_cs = 0; e_op = 2; e_addr = 1024; tag = "R3"; end
    if (n == t2) begin e_cs = 0; e_op = 0; e_ba = 1; e_addr = int'(cfg_drv) << 1; tag = "R6"; end
    if (n == t3) begin e_cs = 0; e_op = 0; e_addr = mr | 256; tag = "R5"; end
    if (n == t5 || n == t6) begin e_cs = 0; e_op = 1; tag = "R3"; end
    if (n == t7) begin e_cs = 0; e_op = 0; e_addr = mr; tag = "R5"; end
    g_cke = int'(cke); g_cs = int'(cs_n); g_op = int'({ras_n, cas_n, we_n});
    g_ba = int'(ba); g_addr = int'(addr); g_done = int'(init_done);
    tests++;
    if (g_cke != e_cke || g_cs != e_cs || g_op != e_op || g_ba != e_ba ||
        g_addr != e_addr || g_done != e_done) begin
      fails++;
      $display("FAIL %s cycle %0d: got cke=%0d cs_n=%0d op=%0d ba=%0d addr=%0d done=%0d, expected cke=%0d cs_n=%0d op=%0d ba=%0d addr=%0d done=%0d",
               tag, n, g_cke, g_cs, g_op, g_ba, g_addr, g_done,
               e_cke, e_cs, e_op, e_ba, e_addr, e_done);
    end
  endtask

  task automatic run(int k);
    repeat (k) begin
      @(posedge clk);
      if (rst) n = 0; else n = n + 1;
      @(negedge clk);
      check_cycle();
    end
  endtask

  task automatic restart(logic [2:0] bl, logic il, logic [2:0] cl, logic drv);
    rst = 1'b1;
    cfg_bl = bl; cfg_il = il; cfg_cl = cl; cfg_drv = drv;
    run(3);
    rst = 1'b0;
  endtask

  initial begin
    t0 = to_cycles(PWR_NS);
    t1 = t0 + 1;
    t2 = t1 + to_cycles(TRP_NS);
    t3 = t2 + TMRD;
    t4 = t3 + ((DLL > TMRD) ? DLL : TMRD);
    t5 = t4 + to_cycles(TRP_NS);
    t6 = t5 + to_cycles(TRFC_NS);
    t7 = t6 + to_cycles(TRFC_NS);
    t8 = t7 + TMRD;
    @(negedge clk);
    // R8 reset state, then R1..R7 with sequential BL4 CL3
    restart(3'b010, 1'b0, 3'b011, 1'b0);
    run(t8 + 12);
    // R5 R6 interleaved BL8 CL2.5 reduced drive; reset after done (R8)
    restart(3'b011, 1'b1, 3'b110, 1'b1);
    run(t8 + 12);
    // R8 reset inside the DLL lock window
    restart(3'b001, 1'b0, 3'b101, 1'b0);
    run(t3 + 40);
    restart(3'b001, 1'b0, 3'b101, 1'b0);
    run(t8 + 12);
    // R8 reset between the two refreshes
    restart(3'b010, 1'b1, 3'b010, 1'b1);
    run(t5 + 3);
    restart(3'b011, 1'b0, 3'b011, 1'b1);
    run(t8 + 12);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not end, got running, expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule